// File: doc/BRIEF.md
# Microstep Translator and Phase Sequencer

This block turns a STEP pulse train and a direction level into the current set points for the two windings of a bipolar stepper motor. It keeps a 6-bit electrical angle index covering one electrical turn in 64 positions of 5.625 degrees. On every rising STEP edge the index moves up or down. The size of the move comes from a 3-bit resolution select that picks full, half, quarter, eighth or sixteenth steps. From the index the block derives an 8-bit magnitude and a sign bit for each phase. Phase 1 follows the cosine of the angle and phase 2 follows the sine.

The block also picks a current decay style for each phase, either slow or mixed. In the automatic modes the choice depends on whether the set point of that phase fell at the most recent step. The STEP input is asynchronous. It goes through a synchroniser before its edge is detected. The direction and resolution inputs are sampled only in the cycle in which an edge is detected. A downstream DAC and chopper consume the set points.

Top module: `ustep_sequencer`

## Requirements
- R1: While `rst_n` is low and after it is released, the angle index is the home position 8 (45 degrees). Both magnitudes are 180, both sign bits are 0 and both mixed flags are 1.
- R2: Each rising STEP edge moves the index by a span chosen by `res_sel` (bit 0 = first select line). Code 3'b000 gives 16, 3'b001 gives 8, 3'b010 gives 4, 3'b011 gives 2 and 3'b111 gives 1.
- R3: With `dir_in` = 1 the span is added to the index, and with `dir_in` = 0 it is subtracted. Both directions wrap modulo 64.
- R4: For an index i, with angle a = i * 5.625 degrees, `ph1_mag` = round(|cos a| * 255) and `ph2_mag` = round(|sin a| * 255). Each sign bit is 1 exactly when its cosine or sine is strictly negative.
- R5: Changes on `dir_in` and `res_sel` between STEP edges leave the index and the outputs unchanged. The next edge uses the values present when that edge is detected.
- R6: STEP passes through two synchroniser flops and an edge register. A STEP level that is first high before clock edge k changes the index at clock edge k+2. Holding STEP high moves the index only once.
- R7: STEP activity while `rst_n` is low has no effect. A STEP level that is already high when reset is released causes no movement.
- R8: A high `rehome` at a clock edge sets the index to home and both mixed flags to 1. This takes priority over a STEP edge detected in the same cycle.
- R9: In automatic decay (`decay_cfg` = 2'b10 or 2'b11), a phase whose new magnitude is lower than its magnitude before the step shows mixed (1). A phase whose new magnitude is equal or higher shows slow (0).
- R10: With `decay_cfg` = 2'b01, both mixed flags are 1 at all times.
- R11: With `decay_cfg` = 2'b00, both mixed flags are 0 while the most recent STEP edge since reset or rehome latched full-step resolution. Otherwise the flags follow the automatic rule of R9.
- R12: The unlisted resolution codes 3'b100, 3'b101 and 3'b110 behave as full step, with a span of 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step pulse; the rising edge advances |
| dir_in | input | 1 | Direction; 1 = index up |
| res_sel | input | 3 | Resolution select |
| decay_cfg | input | 2 | Decay policy: 00 auto with full-step slow, 01 forced mixed, 1x auto |
| rehome | input | 1 | Fault return to home |
| ph1_mag | output | 8 | Phase 1 magnitude, 255 = full scale |
| ph1_neg | output | 1 | Phase 1 negative polarity |
| ph2_mag | output | 8 | Phase 2 magnitude |
| ph2_neg | output | 1 | Phase 2 negative polarity |
| ph1_mixed | output | 1 | Phase 1 mixed decay (0 = slow) |
| ph2_mixed | output | 1 | Phase 2 mixed decay |
| angle_idx | output | 6 | Current electrical angle index |

## Verification
A wrong index shows on `angle_idx` and in both magnitudes at the third clock edge after STEP rises. From then on every later position carries the error, because the index only ever accumulates. A wrong quadrant or table entry shows as a magnitude or sign mismatch only at the indices that use that entry, so the sweep visits all 64 positions in both directions. A wrong decay comparison shows on the mixed flags in the same cycle as the index update. It shows only at the steps where a magnitude changes, so runs through every quadrant expose both the rising and the falling case.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int IDX_W    = 6;
  localparam int MAG_W    = 8;
  localparam int HOME_IDX = 8;
  localparam int FULL_SPAN = 16;

  typedef struct packed {
    logic [MAG_W-1:0] mag;
    logic             neg;
  } phase_t;

  // span in sixteenth positions per step for a resolution code
  function automatic logic [4:0] step_span(input logic [2:0] sel);
    case (sel)
      3'b001:  step_span = 5'd8;
      3'b010:  step_span = 5'd4;
      3'b011:  step_span = 5'd2;
      3'b111:  step_span = 5'd1;
      default: step_span = 5'd16;
    endcase
  endfunction

  // |cos(k * 5.625 deg)| * 255, rounded, for k = 0..16
  function automatic logic [MAG_W-1:0] quarter_cos(input logic [4:0] k);
    case (k)
      5'd0:  quarter_cos = 8'd255;
      5'd1:  quarter_cos = 8'd254;
      5'd2:  quarter_cos = 8'd250;
      5'd3:  quarter_cos = 8'd244;
      5'd4:  quarter_cos = 8'd236;
      5'd5:  quarter_cos = 8'd225;
      5'd6:  quarter_cos = 8'd212;
      5'd7:  quarter_cos = 8'd197;
      5'd8:  quarter_cos = 8'd180;
      5'd9:  quarter_cos = 8'd162;
      5'd10: quarter_cos = 8'd142;
      5'd11: quarter_cos = 8'd120;
      5'd12: quarter_cos = 8'd98;
      5'd13: quarter_cos = 8'd74;
      5'd14: quarter_cos = 8'd50;
      5'd15: quarter_cos = 8'd25;
      default: quarter_cos = 8'd0;
    endcase
  endfunction

  function automatic phase_t cos_of(input logic [IDX_W-1:0] idx);
    logic [1:0] q;
    logic [3:0] r;
    q = idx[5:4];
    r = idx[3:0];
    cos_of.mag = q[0] ? quarter_cos(5'd16 - {1'b0, r}) : quarter_cos({1'b0, r});
    cos_of.neg = (q == 2'd2) || ((q == 2'd1) && (r != 4'd0));
  endfunction

  // sin(a) = cos(a - 90 deg)
  function automatic phase_t sin_of(input logic [IDX_W-1:0] idx);
    sin_of = cos_of(idx - 6'd16);
  endfunction
endpackage

// File: rtl/ustep_edge_sync.sv
module ustep_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              hist;

  // flops reset high: a level already high at release is not an edge
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= (g == 0) ? async_in : chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= 1'b1;
    else        hist <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~hist;
endmodule

// File: rtl/ustep_angle.sv
module ustep_angle
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             rehome,
  input  logic             dir,
  input  logic [2:0]       sel,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_d,
  output logic             adv,
  output logic             full_q
);
  logic [4:0]       span;
  logic [IDX_W-1:0] span_w;

  assign span   = step_span(sel);
  assign span_w = IDX_W'(span);
  assign adv    = rise & ~rehome;

  always_comb begin
    if (rehome)   idx_d = IDX_W'(HOME_IDX);
    else if (adv) idx_d = dir ? idx_q + span_w : idx_q - span_w;
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDX_W'(HOME_IDX);
      full_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      if (rehome)   full_q <= 1'b0;
      else if (adv) full_q <= (span == 5'(FULL_SPAN));
    end
  end
endmodule

// File: rtl/ustep_profile.sv
module ustep_profile
  import ustep_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output phase_t           ph1,
  output phase_t           ph2
);
  assign ph1 = cos_of(idx);
  assign ph2 = sin_of(idx);
endmodule

// File: rtl/ustep_decay.sv
module ustep_decay
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             rehome,
  input  logic [1:0]       cfg,
  input  logic             full_q,
  input  logic [MAG_W-1:0] cur1,
  input  logic [MAG_W-1:0] cur2,
  input  logic [MAG_W-1:0] nxt1,
  input  logic [MAG_W-1:0] nxt2,
  output logic             mixed1,
  output logic             mixed2
);
  logic auto1_q, auto2_q;
  logic force_mixed, force_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto1_q <= 1'b1;
      auto2_q <= 1'b1;
    end else if (rehome) begin
      auto1_q <= 1'b1;
      auto2_q <= 1'b1;
    end else if (adv) begin
      auto1_q <= nxt1 < cur1;
      auto2_q <= nxt2 < cur2;
    end
  end

  assign force_mixed = (cfg == 2'b01);
  assign force_slow  = (cfg == 2'b00) && full_q;
  assign mixed1 = force_mixed | (~force_slow & auto1_q);
  assign mixed2 = force_mixed | (~force_slow & auto2_q);
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
  import ustep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [2:0]       res_sel,
  input  logic [1:0]       decay_cfg,
  input  logic             rehome,
  output logic [MAG_W-1:0] ph1_mag,
  output logic             ph1_neg,
  output logic [MAG_W-1:0] ph2_mag,
  output logic             ph2_neg,
  output logic             ph1_mixed,
  output logic             ph2_mixed,
  output logic [IDX_W-1:0] angle_idx
);
  logic             step_rise;
  logic             step_adv;
  logic             full_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  phase_t           cur1, cur2, nxt1, nxt2;

  ustep_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(step_in), .rise(step_rise)
  );

  ustep_angle u_angle (
    .clk(clk), .rst_n(rst_n), .rise(step_rise), .rehome(rehome),
    .dir(dir_in), .sel(res_sel), .idx_q(idx_q), .idx_d(idx_d),
    .adv(step_adv), .full_q(full_q)
  );

  ustep_profile u_prof_cur (.idx(idx_q), .ph1(cur1), .ph2(cur2));
  ustep_profile u_prof_nxt (.idx(idx_d), .ph1(nxt1), .ph2(nxt2));

  ustep_decay u_decay (
    .clk(clk), .rst_n(rst_n), .adv(step_adv), .rehome(rehome),
    .cfg(decay_cfg), .full_q(full_q),
    .cur1(cur1.mag), .cur2(cur2.mag), .nxt1(nxt1.mag), .nxt2(nxt2.mag),
    .mixed1(ph1_mixed), .mixed2(ph2_mixed)
  );

  assign ph1_mag   = cur1.mag;
  assign ph1_neg   = cur1.neg;
  assign ph2_mag   = cur2.mag;
  assign ph2_neg   = cur2.neg;
  assign angle_idx = idx_q;
endmodule

// File: rtl/ustep_sequencer_chk.sv
module ustep_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rise,
  input logic       adv,
  input logic       rehome,
  input logic [1:0] decay_cfg,
  input logic [5:0] angle_idx,
  input logic [7:0] ph1_mag,
  input logic [7:0] ph2_mag,
  input logic       ph1_neg,
  input logic       ph2_neg,
  input logic       ph1_mixed,
  input logic       ph2_mixed
);
  logic [5:0] prev_idx;
  logic [5:0] fwd, bwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_idx <= 6'd8;
    else        prev_idx <= angle_idx;
  end
  assign fwd = angle_idx - prev_idx;
  assign bwd = prev_idx - angle_idx;

  p_rehome_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rehome |=> angle_idx == 6'd8);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !rehome) |=> $stable(angle_idx));

  p_one_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ($countones(fwd) == 1 || $countones(bwd) == 1));

  p_forced_mixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    decay_cfg == 2'b01 |-> (ph1_mixed && ph2_mixed));

  p_peak_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_mag >= 8'd180 || ph2_mag >= 8'd180);

  p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph1_mag == 8'd0 |-> !ph1_neg) and (ph2_mag == 8'd0 |-> !ph2_neg));

  p_drop_mixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && decay_cfg[1] && $stable(decay_cfg)) |=>
      (ph1_mixed == (ph1_mag < $past(ph1_mag)) && ph2_mixed == (ph2_mag < $past(ph2_mag))));
endmodule

bind ustep_sequencer ustep_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(step_rise), .adv(step_adv), .rehome(rehome),
  .decay_cfg(decay_cfg), .angle_idx(angle_idx), .ph1_mag(ph1_mag), .ph2_mag(ph2_mag),
  .ph1_neg(ph1_neg), .ph2_neg(ph2_neg), .ph1_mixed(ph1_mixed), .ph2_mixed(ph2_mixed)
);

// File: tb/test_ustep_sequencer.sv
`timescale 1ns/1ps
module test_ustep_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic [2:0] res_sel = 3'b111;
  logic [1:0] decay_cfg = 2'b10;
  logic       rehome = 1'b0;
  logic [7:0] ph1_mag, ph2_mag;
  logic       ph1_neg, ph2_neg, ph1_mixed, ph2_mixed;
  logic [5:0] angle_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  int m_idx = 8;
  bit m_mix1 = 1, m_mix2 = 1;
  bit m_full = 0;

  always #4 clk = ~clk;

  ustep_sequencer i_ustep_sequencer (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .res_sel(res_sel), .decay_cfg(decay_cfg), .rehome(rehome),
    .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph2_mag(ph2_mag), .ph2_neg(ph2_neg),
    .ph1_mixed(ph1_mixed), .ph2_mixed(ph2_mixed), .angle_idx(angle_idx)
  );

  function automatic real ang_val(int idx, bit use_sin);
    real a;
    a = idx * 5.625 * 3.14159265358979 / 180.0;
    return use_sin ? $sin(a) : $cos(a);
  endfunction

  function automatic int exp_mag(int idx, bit use_sin);
    real v;
    v = ang_val(idx, use_sin);
    if (v < 0.0) v = -v;
    return $rtoi(v * 255.0 + 0.5);
  endfunction

  function automatic bit exp_neg(int idx, bit use_sin);
    return ang_val(idx, use_sin) < -1.0e-6;
  endfunction

  function automatic int span_of(logic [2:0] s);
    case (s)
      3'b001: return 8;
      3'b010: return 4;
      3'b011: return 2;
      3'b111: return 1;
      default: return 16;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit e1, e2;
    e1 = (decay_cfg == 2'b01) ? 1'b1 : ((decay_cfg == 2'b00 && m_full) ? 1'b0 : m_mix1);
    e2 = (decay_cfg == 2'b01) ? 1'b1 : ((decay_cfg == 2'b00 && m_full) ? 1'b0 : m_mix2);
    chk(req, "angle_idx", angle_idx, m_idx);
    chk(req, "ph1_mag", ph1_mag, exp_mag(m_idx, 0));
    chk(req, "ph2_mag", ph2_mag, exp_mag(m_idx, 1));
    chk(req, "ph1_neg", ph1_neg, exp_neg(m_idx, 0));
    chk(req, "ph2_neg", ph2_neg, exp_neg(m_idx, 1));
    chk(req, "ph1_mixed", ph1_mixed, e1);
    chk(req, "ph2_mixed", ph2_mixed, e2);
  endtask

  task automatic model_step(logic [2:0] s, logic d);
    int n;
    n = d ? (m_idx + span_of(s)) % 64 : (m_idx - span_of(s) + 64) % 64;
    m_mix1 = exp_mag(n, 0) < exp_mag(m_idx, 0);
    m_mix2 = exp_mag(n, 1) < exp_mag(m_idx, 1);
    m_full = (span_of(s) == 16);
    m_idx  = n;
  endtask

  task automatic do_step(logic [2:0] s, logic d, string req);
    @(negedge clk);
    res_sel = s;
    dir_in  = d;
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    model_step(s, d);
    check_all(req);
  endtask

  task automatic model_home();
    m_idx = 8; m_mix1 = 1; m_mix2 = 1; m_full = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 / R7: reset state, STEP activity during reset ignored
    repeat (2) @(negedge clk);
    check_all("R1");
    step_in = 1'b1; repeat (3) @(negedge clk);
    step_in = 1'b0; repeat (3) @(negedge clk);
    step_in = 1'b1; repeat (3) @(negedge clk);
    check_all("R7");
    rst_n = 1'b1;                 // STEP still high at release
    repeat (6) @(negedge clk);
    check_all("R7");
    step_in = 1'b0; repeat (3) @(negedge clk);
    check_all("R1");

    // R2/R3/R4/R9: full sixteenth sweep both directions
    for (int i = 0; i < 64; i++) do_step(3'b111, 1'b1, "R4");
    for (int i = 0; i < 64; i++) do_step(3'b111, 1'b0, "R3");
    for (int i = 0; i < 33; i++) do_step(3'b011, 1'b1, "R2");
    for (int i = 0; i < 17; i++) do_step(3'b010, 1'b0, "R9");
    for (int i = 0; i < 9;  i++) do_step(3'b001, 1'b1, "R2");
    for (int i = 0; i < 5;  i++) do_step(3'b000, 1'b0, "R3");

    // R12: unlisted codes behave as full step
    do_step(3'b100, 1'b1, "R12");
    do_step(3'b101, 1'b1, "R12");
    do_step(3'b110, 1'b0, "R12");

    // R5: input changes between edges have no effect
    do_step(3'b111, 1'b1, "R5");
    @(negedge clk); dir_in = 1'b0; res_sel = 3'b000;
    repeat (5) @(negedge clk);
    check_all("R5");
    dir_in = 1'b1; res_sel = 3'b011;
    repeat (5) @(negedge clk);
    check_all("R5");

    // R6: latency of the synchroniser and edge register, one move per pulse
    @(negedge clk);
    res_sel = 3'b111; dir_in = 1'b1; step_in = 1'b1;
    @(negedge clk);                      // after edge k
    @(negedge clk);                      // after edge k+1
    chk("R6", "idx before update", angle_idx, m_idx);
    @(negedge clk);                      // after edge k+2
    model_step(3'b111, 1'b1);
    chk("R6", "idx at third edge", angle_idx, m_idx);
    repeat (10) @(negedge clk);
    check_all("R6");
    step_in = 1'b0; repeat (3) @(negedge clk);
    check_all("R6");

    // R8: rehome alone, then colliding with a detected edge
    @(negedge clk); rehome = 1'b1;
    @(negedge clk); rehome = 1'b0;
    model_home();
    check_all("R8");
    do_step(3'b011, 1'b1, "R8");
    @(negedge clk); res_sel = 3'b000; step_in = 1'b1;
    @(negedge clk);
    @(negedge clk); rehome = 1'b1;
    @(negedge clk); rehome = 1'b0;
    model_home();
    check_all("R8");
    step_in = 1'b0; repeat (4) @(negedge clk);
    check_all("R8");

    // R10: forced mixed
    decay_cfg = 2'b01;
    for (int i = 0; i < 6; i++) do_step(3'b011, i < 3, "R10");

    // R11: full step forces slow under cfg 00, then auto returns
    decay_cfg = 2'b00;
    @(negedge clk); check_all("R11");
    for (int i = 0; i < 4; i++) do_step(3'b000, 1'b1, "R11");
    for (int i = 0; i < 8; i++) do_step(3'b111, 1'b0, "R11");
    do_step(3'b000, 1'b0, "R11");

    // R9 with the alternate auto code
    decay_cfg = 2'b11;
    for (int i = 0; i < 20; i++) do_step(3'b010, 1'b1, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule